// File: doc/BRIEF.md
# Glitch-Free Clock Output Gate

This block switches one free-running clock output on and off while the source clock keeps running. Two enables control it: an asynchronous pin and a bit from a control register. The output runs only while both are high. Pulling either one low stops the output, and a stopped output rests low. The combined enable is brought into the clock's timing by a synchroniser that samples on the falling edge of the source clock. A small state machine then decides when the gate opens or closes.

The gate flop changes only on the falling edge of the source clock, while the source is low. The output is the source clock ANDed with that flop. A stop therefore never cuts a high phase short, and a restart never produces a partial pulse. A status output shows whether the gate is open. After reset the output stays stopped until the synchroniser has filled with real samples of the enable.

The controller has three states. `GS_HOLD` is the state after reset, and it waits for the synchroniser to fill. `GS_OFF` means the gate is closed. `GS_ON` means the gate is open. The transitions are:
- HOLD_TO_ON: from `GS_HOLD` when the synchroniser is filled and the synchronised enable is high.
- HOLD_TO_OFF: from `GS_HOLD` when the synchroniser is filled and the synchronised enable is low.
- OFF_TO_ON: from `GS_OFF` when the synchronised enable rises.
- ON_TO_OFF: from `GS_ON` when the synchronised enable falls.

Every other state and input combination holds the current state.

Top module: `clkgate_top`

## Requirements
- R1: `clk_out` carries source pulses only while both `en_pin` and `en_reg` are high. With only one of the two high, no pulse appears.
- R2: Driving `en_pin` low, with `en_reg` high, stops `clk_out` within 6 source cycles.
- R3: Driving `en_reg` low, with `en_pin` high, stops `clk_out` within 6 source cycles.
- R4: While stopped, `clk_out` is held at logic 0.
- R5: Every `clk_out` pulse rises together with a source rising edge and lasts a full source high phase. No pulse is shortened, including when the enable is toggled for less than a cycle at any phase.
- R6: After the combined enable rises, the first `clk_out` pulse appears on the 2nd to 6th source rising edge that follows.
- R7: `running` is 1 exactly while the gate is open. At the middle of every source high phase, `running` equals `clk_out`.
- R8: During reset, and for the first two source falling edges after reset is released, `clk_out` and `running` stay 0 even when both enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_pin | input | 1 | Asynchronous enable pin, active high |
| en_reg | input | 1 | Register enable bit, active high |
| clk_out | output | 1 | Gated clock output |
| running | output | 1 | High while the gate is open |

## Verification
The hardest case to reach is an enable change that lands close to the sampling edge, or that is shorter than one source cycle. Such a change could, in a faulty gate, open or close the gate part way through a high phase. The bench reaches this case by pulsing the pin for 1.5 ns at several offsets inside a cycle. A monitor times every output pulse against the source phase and reports any pulse that is shortened or that rises off a source edge.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

    // Number of falling-edge flops between the raw enable and the controller
    parameter int unsigned SYNC_DEPTH_DEF = 2;

    typedef enum logic [1:0] {
        GS_HOLD = 2'd0,
        GS_OFF  = 2'd1,
        GS_ON   = 2'd2
    } gate_state_e;

endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync,
    output logic filled
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic [STAGES-1:0] fill;

    // Sampled on the falling edge so results land while the source is low
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
            fill  <= '0;
        end else begin
            chain[0] <= d_async;
            fill[0]  <= 1'b1;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
                fill[i]  <= fill[i-1];
            end
        end
    end

    assign q_sync = chain[LAST];
    assign filled = fill[LAST];
endmodule

// File: rtl/clkgate_fsm.sv
module clkgate_fsm
    import clkgate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_s,
    input  logic sync_vld,
    output logic gate_q
);
    gate_state_e state_q, state_d;
    logic        gate_d;

    // State register and registered gate, both on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_HOLD;
            gate_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            gate_q  <= gate_d;
        end
    end

    // Next-state and output decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_HOLD: begin
                if (sync_vld) state_d = en_s ? GS_ON : GS_OFF; // HOLD_TO_ON / HOLD_TO_OFF
            end
            GS_OFF: begin
                if (en_s) state_d = GS_ON;                     // OFF_TO_ON
            end
            GS_ON: begin
                if (!en_s) state_d = GS_OFF;                   // ON_TO_OFF
            end
            default: state_d = GS_HOLD;
        endcase
        gate_d = (state_d == GS_ON);
    end
endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell (
    input  logic clk_in,
    input  logic gate,
    output logic clk_out
);
    // gate only moves while clk_in is low, so the product has no runts
    assign clk_out = clk_in & gate;
endmodule

// File: rtl/clkgate_top.sv
module clkgate_top
    import clkgate_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_DEPTH_DEF
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic en_pin,
    input  logic en_reg,
    output logic clk_out,
    output logic running
);
    logic en_raw;
    logic en_s;
    logic sync_vld;
    logic gate_q;

    assign en_raw = en_pin & en_reg;

    clkgate_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .d_async (en_raw),
        .q_sync  (en_s),
        .filled  (sync_vld)
    );

    clkgate_fsm u_fsm (
        .clk      (clk_src),
        .rst_n    (rst_n),
        .en_s     (en_s),
        .sync_vld (sync_vld),
        .gate_q   (gate_q)
    );

    clkgate_cell u_cell (
        .clk_in  (clk_src),
        .gate    (gate_q),
        .clk_out (clk_out)
    );

    assign running = gate_q;
endmodule

// File: rtl/clkgate_chk.sv
module clkgate_chk (
    input logic clk_src,
    input logic rst_n,
    input logic en_pin,
    input logic en_reg,
    input logic clk_out,
    input logic running,
    input logic en_s,
    input logic sync_vld
);
    logic [3:0] wait_cnt;

    // Falling edges spent with the combined enable high and the gate closed
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n)                           wait_cnt <= '0;
        else if (!(en_pin && en_reg) || running) wait_cnt <= '0;
        else if (wait_cnt != 4'hF)            wait_cnt <= wait_cnt + 4'd1;
    end

    // R4 / R7: an output pulse only happens with the gate open
    always @(posedge clk_out) begin
        if (rst_n) begin
            p_pulse_needs_gate_r4: assert (running && clk_src);
        end
    end

    // R1: a synchronised enable opens the gate at that edge
    p_open_on_enable_r1: assert property (@(negedge clk_src) disable iff (!rst_n)
        (sync_vld && en_s) |=> running);

    // R2 / R3: a synchronised low enable closes the gate
    p_close_on_disable_r2: assert property (@(negedge clk_src) disable iff (!rst_n)
        (sync_vld && !en_s) |=> !running);

    // R8: no opening before the synchroniser is filled
    p_hold_after_reset_r8: assert property (@(negedge clk_src) disable iff (!rst_n)
        !sync_vld |-> !running);

    // R6: resume window bounded
    p_resume_window_r6: assert property (@(negedge clk_src) disable iff (!rst_n)
        wait_cnt <= 4'd5);
endmodule

bind clkgate_top clkgate_chk u_chk (
    .clk_src  (clk_src),
    .rst_n    (rst_n),
    .en_pin   (en_pin),
    .en_reg   (en_reg),
    .clk_out  (clk_out),
    .running  (running),
    .en_s     (en_s),
    .sync_vld (sync_vld)
);

// File: tb/sim_clkgate_top.sv
`timescale 1ns/1ps
module sim_clkgate_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_pin = 1'b0;
    logic en_reg = 1'b0;
    logic clk_out;
    logic running;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    realtime rise_t = 0.0;

    clkgate_top u0 (
        .clk_src (clk),
        .rst_n   (rst_n),
        .en_pin  (en_pin),
        .en_reg  (en_reg),
        .clk_out (clk_out),
        .running (running)
    );

    always #2 clk = ~clk; // 250 MHz

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // sample point: middle of the source high phase
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // R5: pulse shape monitor
    always @(posedge clk_out) begin
        rise_t = $realtime;
        check(clk === 1'b1, "R5 rise off source edge", int'(clk), 1);
    end
    always @(negedge clk_out) begin
        realtime w;
        w = $realtime - rise_t;
        check(w > 1.99 && w < 2.01, "R5 pulse width ps", int'(w * 1000.0), 2000);
    end

    // R7: status matches output in every high phase
    always @(posedge clk) begin
        #1;
        if (!finished) check(running === clk_out, "R7 running vs clk_out", int'(running), int'(clk_out));
    end

    task automatic t_reset();
        en_pin = 1'b1; en_reg = 1'b1;
        repeat (3) begin
            step();
            check(clk_out === 1'b0, "R8 clk_out in reset", int'(clk_out), 0);
            check(running === 1'b0, "R8 running in reset", int'(running), 0);
        end
        #0.5 rst_n = 1'b1;
        for (int i = 0; i < 2; i++) begin
            step();
            check(clk_out === 1'b0, "R8 clk_out before fill", int'(clk_out), 0);
        end
        step();
        check(clk_out === 1'b1, "R6 first pulse after reset", int'(clk_out), 1);
    endtask

    task automatic measure_resume(output int k);
        k = 0;
        for (int i = 1; i <= 8; i++) begin
            step();
            if (clk_out === 1'b1 && k == 0) k = i;
        end
    endtask

    task automatic measure_stop(output int k);
        k = 0;
        for (int i = 1; i <= 8; i++) begin
            step();
            if (clk_out === 1'b0 && k == 0) k = i;
        end
    endtask

    task automatic t_pin_stop();
        int k;
        en_pin = 1'b0;
        measure_stop(k);
        check(k >= 1 && k <= 6, "R2 stop latency", k, 3);
        repeat (10) begin
            step();
            check(clk_out === 1'b0, "R4 low after pin stop", int'(clk_out), 0);
        end
        en_pin = 1'b1;
        measure_resume(k);
        check(k >= 2 && k <= 6, "R6 resume latency after pin", k, 3);
    endtask

    task automatic t_reg_stop();
        int k;
        en_reg = 1'b0;
        measure_stop(k);
        check(k >= 1 && k <= 6, "R3 stop latency", k, 3);
        repeat (10) begin
            step();
            check(clk_out === 1'b0, "R4 low after reg stop", int'(clk_out), 0);
            check(running === 1'b0, "R7 running low after reg stop", int'(running), 0);
        end
        en_reg = 1'b1;
        measure_resume(k);
        check(k >= 2 && k <= 6, "R6 resume latency after reg", k, 3);
    endtask

    task automatic t_both_needed();
        int hi;
        en_pin = 1'b1; en_reg = 1'b0;
        repeat (6) step();
        hi = 0;
        repeat (10) begin step(); if (clk_out === 1'b1) hi++; end
        check(hi == 0, "R1 pin only", hi, 0);
        en_pin = 1'b0; en_reg = 1'b1;
        repeat (6) step();
        hi = 0;
        repeat (10) begin step(); if (clk_out === 1'b1) hi++; end
        check(hi == 0, "R1 reg only", hi, 0);
        en_pin = 1'b1;
        repeat (6) step();
        hi = 0;
        repeat (10) begin step(); if (clk_out === 1'b1) hi++; end
        check(hi == 10, "R1 both high every cycle", hi, 10);
    endtask

    task automatic t_blips();
        en_pin = 1'b0;
        repeat (8) step();
        for (int off = 0; off < 5; off++) begin
            @(posedge clk);
            #(0.3 + 0.8 * off);
            en_pin = 1'b1;
            #1.5;
            en_pin = 1'b0;
            repeat (10) step();
            check(clk_out === 1'b0, "R4 low after blip", int'(clk_out), 0);
        end
        en_pin = 1'b1;
        repeat (8) step();
        check(clk_out === 1'b1, "R1 running after blips", int'(clk_out), 1);
    endtask

    initial begin
        t_reset();
        repeat (4) step();
        t_pin_stop();
        t_reg_stop();
        t_both_needed();
        t_blips();
        repeat (4) step();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule